// File: doc/BRIEF.md
# Dual-Pipe Issue Latency Scoreboard

This block decides, every cycle, which of two decoded instructions from an in-order vector front end may leave for execution. Each instruction has an operation class, a destination register and two source registers. The class fixes both the pipe the instruction runs on and the number of cycles until its result can be read. For each register the block keeps a countdown of the cycles left until its pending result arrives. An instruction issues only when all of its sources have reached zero.

Slot 0 holds the older instruction and slot 1 the younger. Both issue together only when they use different pipes and the younger one does not read what the older one writes. The double-precision unit accepts a new operation only once every six cycles, which adds a structural stall on top of the data hazards. The go and stall outputs are combinational on the current inputs and table state. Register updates take effect at the next rising clock edge.

Top module: `vec_issue_sb`

## Requirements
- R1: Class codes 0–5 (simple integer, shift, complex integer, single float, conversion, double) run on pipe 0. Codes 6–15 (shuffle, load/store, branch, reserved) run on pipe 1. `pipe_iss[p]` is high when an instruction issues on pipe p.
- R2: A reader of a register written by class code c can issue exactly L cycles after the writer issued, and not earlier. L is 2, 4, 7, 6, 7, 13, 4, 6 for codes 0 to 7.
- R3: An instruction issues only while both of its source countdowns are zero. Otherwise it is held with its go output low.
- R4: Once a double-precision instruction (code 5) issues, no other double issues in the next 5 cycles, from either slot. One may issue in the 6th cycle.
- R5: Slot 1 issues together with slot 0 only if the two target different pipes and neither slot 1 source equals the register that slot 0 writes.
- R6: Slot 1 never issues in a cycle in which slot 0 does not issue.
- R7: When a register already has a pending result and a shorter write to it issues, the countdown keeps the longer remaining time.
- R8: A synchronous reset (`rst` high at a rising edge) clears every countdown and the double-unit gap, so that afterwards every register is ready and a double may issue at once.
- R9: `pipe_stall[p]` is high when a valid instruction routed to pipe p is presented and does not issue in that cycle.
- R10: An instruction whose write enable is low, or whose class code is 8–15, does not mark its destination pending. A reader of that register can issue in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_vld | input | 1 | Slot 0 (older) instruction valid |
| s0_cls | input | 4 | Slot 0 class code |
| s0_wen | input | 1 | Slot 0 writes its destination |
| s0_dst | input | 7 | Slot 0 destination register |
| s0_sa | input | 7 | Slot 0 first source register |
| s0_sb | input | 7 | Slot 0 second source register |
| s1_vld | input | 1 | Slot 1 (younger) instruction valid |
| s1_cls | input | 4 | Slot 1 class code |
| s1_wen | input | 1 | Slot 1 writes its destination |
| s1_dst | input | 7 | Slot 1 destination register |
| s1_sa | input | 7 | Slot 1 first source register |
| s1_sb | input | 7 | Slot 1 second source register |
| s0_go | output | 1 | Slot 0 issues this cycle |
| s1_go | output | 1 | Slot 1 issues this cycle |
| pipe_iss | output | 2 | Per-pipe issue indication |
| pipe_stall | output | 2 | Per-pipe stall indication |

## Verification
The go, issue and stall outputs are due in the same cycle as the inputs that cause them. The bench therefore drives each cycle's inputs just after a rising edge and samples the outputs a few nanoseconds later, before the next edge. A write becomes visible in the countdown table at the edge that ends its issue cycle. A dependent reader is then offered in every following cycle, and its go must stay low until exactly the class latency has elapsed and rise in that cycle. The double-unit gap, the longer-write retention and the reset clearing are counted in the same way, in whole cycles from the issuing edge.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

  localparam int CLS_W   = 4;
  localparam int CNT_W   = 4;
  localparam int DBL_GAP = 6;

  typedef enum logic [CLS_W-1:0] {
    OC_ISIMP = 4'd0,
    OC_ISHFT = 4'd1,
    OC_ICPLX = 4'd2,
    OC_FSGL  = 4'd3,
    OC_FCONV = 4'd4,
    OC_FDBL  = 4'd5,
    OC_SHUF  = 4'd6,
    OC_LDST  = 4'd7,
    OC_BRCH  = 4'd8
  } op_cls_e;

  // cycles from issue until the result may be consumed
  function automatic logic [CNT_W-1:0] cls_latency(input logic [CLS_W-1:0] c);
    logic [CNT_W-1:0] l;
    case (c)
      OC_ISIMP: l = 4'd2;
      OC_ISHFT: l = 4'd4;
      OC_ICPLX: l = 4'd7;
      OC_FSGL:  l = 4'd6;
      OC_FCONV: l = 4'd7;
      OC_FDBL:  l = 4'd13;
      OC_SHUF:  l = 4'd4;
      OC_LDST:  l = 4'd6;
      default:  l = 4'd1;
    endcase
    return l;
  endfunction

  // 0: arithmetic pipe, 1: permute/memory/branch pipe
  function automatic logic cls_pipe(input logic [CLS_W-1:0] c);
    return (c >= OC_SHUF);
  endfunction

  function automatic logic cls_writes(input logic [CLS_W-1:0] c);
    return (c <= OC_LDST);
  endfunction

  function automatic logic cls_is_dbl(input logic [CLS_W-1:0] c);
    return (c == OC_FDBL);
  endfunction

  // one cycle of countdown, saturating at zero
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] keep_longer(input logic [CNT_W-1:0] a,
                                                   input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vsb_ready_table.sv
module vsb_ready_table
  import vsb_pkg::*;
#(
  parameter int NREG = 128,
  localparam int AW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wa_en,
  input  logic [AW-1:0]    wa_idx,
  input  logic [CNT_W-1:0] wa_val,
  input  logic             wb_en,
  input  logic [AW-1:0]    wb_idx,
  input  logic [CNT_W-1:0] wb_val,
  output logic [NREG-1:0]  rdy
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;
    logic             hit_a;
    logic             hit_b;

    assign hit_a = wa_en && (wa_idx == AW'(g));
    assign hit_b = wb_en && (wb_idx == AW'(g));

    always_comb begin
      nxt = count_step(cnt);
      if (hit_a) nxt = keep_longer(nxt, wa_val);
      if (hit_b) nxt = keep_longer(nxt, wb_val);
    end

    always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= nxt;
    end

    assign rdy[g] = (cnt == '0);

    // R2: without a write the count only ever steps down by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
      (!hit_a && !hit_b && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R7: a write never shortens what was already pending
    p_keep_longer_r7: assert property (@(posedge clk) disable iff (rst)
      (hit_a || hit_b) |=> (cnt >= $past(count_step(cnt))));

    // R7: a write always leaves at least its own latency pending
    p_write_floor_r7: assert property (@(posedge clk) disable iff (rst)
      hit_a |=> (cnt >= $past(wa_val)));
  end

endmodule

// File: rtl/vsb_dbl_unit.sv
module vsb_dbl_unit #(
  parameter int GAP = 6,
  localparam int BW = $clog2(GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic dbl_fire,
  output logic busy
);

  logic [BW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)           left <= '0;
    else if (dbl_fire) left <= BW'(GAP - 1);
    else if (left != '0) left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R4: the issue logic never launches a double into a busy unit
  p_dbl_gap_r4: assert property (@(posedge clk) disable iff (rst)
    dbl_fire |-> !busy);

  // R4: a launch makes the unit busy for the following cycle
  p_dbl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    dbl_fire |=> busy);

  // R8: reset leaves the unit free
  p_reset_free_r8: assert property (@(posedge clk)
    rst |=> !busy);

endmodule

// File: rtl/vsb_issue_ctl.sv
module vsb_issue_ctl
  import vsb_pkg::*;
#(
  parameter int NREG = 128,
  localparam int AW = $clog2(NREG)
) (
  input  logic             s0_vld,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic             s0_wen,
  input  logic [AW-1:0]    s0_dst,
  input  logic [AW-1:0]    s0_sa,
  input  logic [AW-1:0]    s0_sb,
  input  logic             s1_vld,
  input  logic [CLS_W-1:0] s1_cls,
  input  logic             s1_wen,
  input  logic [AW-1:0]    s1_dst,
  input  logic [AW-1:0]    s1_sa,
  input  logic [AW-1:0]    s1_sb,
  input  logic [NREG-1:0]  rdy,
  input  logic             dbl_busy,
  output logic             go0,
  output logic             go1,
  output logic [1:0]       p_iss,
  output logic [1:0]       p_stall,
  output logic             wa_en,
  output logic [AW-1:0]    wa_idx,
  output logic [CNT_W-1:0] wa_val,
  output logic             wb_en,
  output logic [AW-1:0]    wb_idx,
  output logic [CNT_W-1:0] wb_val,
  output logic             dbl_fire
);

  logic pipe0, pipe1;
  logic srcs0_ok, srcs1_ok;
  logic unit0_ok, unit1_ok;
  logic wr0, wr1;
  logic raw_pair;
  logic pipes_differ;

  assign pipe0 = cls_pipe(s0_cls);
  assign pipe1 = cls_pipe(s1_cls);

  assign srcs0_ok = rdy[s0_sa] && rdy[s0_sb];
  assign srcs1_ok = rdy[s1_sa] && rdy[s1_sb];

  assign unit0_ok = !(cls_is_dbl(s0_cls) && dbl_busy);
  assign unit1_ok = !(cls_is_dbl(s1_cls) && dbl_busy);

  assign wr0 = s0_wen && cls_writes(s0_cls);
  assign wr1 = s1_wen && cls_writes(s1_cls);

  assign raw_pair     = wr0 && ((s1_sa == s0_dst) || (s1_sb == s0_dst));
  assign pipes_differ = (pipe0 != pipe1);

  assign go0 = s0_vld && srcs0_ok && unit0_ok;
  assign go1 = go0 && s1_vld && pipes_differ && !raw_pair && srcs1_ok && unit1_ok;

  for (genvar p = 0; p < 2; p++) begin : g_pipe
    logic on0, on1;
    assign on0 = (pipe0 == 1'(p));
    assign on1 = (pipe1 == 1'(p));
    assign p_iss[p]   = (go0 && on0) || (go1 && on1);
    assign p_stall[p] = (s0_vld && !go0 && on0) || (s1_vld && !go1 && on1);
  end

  assign wa_en  = go0 && wr0;
  assign wa_idx = s0_dst;
  assign wa_val = cls_latency(s0_cls) - 1'b1;
  assign wb_en  = go1 && wr1;
  assign wb_idx = s1_dst;
  assign wb_val = cls_latency(s1_cls) - 1'b1;

  assign dbl_fire = (go0 && cls_is_dbl(s0_cls)) || (go1 && cls_is_dbl(s1_cls));

endmodule

// File: rtl/vec_issue_sb.sv
module vec_issue_sb
  import vsb_pkg::*;
#(
  parameter int NREG    = 128,
  parameter int GAP     = DBL_GAP,
  localparam int AW     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s0_vld,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic             s0_wen,
  input  logic [AW-1:0]    s0_dst,
  input  logic [AW-1:0]    s0_sa,
  input  logic [AW-1:0]    s0_sb,
  input  logic             s1_vld,
  input  logic [CLS_W-1:0] s1_cls,
  input  logic             s1_wen,
  input  logic [AW-1:0]    s1_dst,
  input  logic [AW-1:0]    s1_sa,
  input  logic [AW-1:0]    s1_sb,
  output logic             s0_go,
  output logic             s1_go,
  output logic [1:0]       pipe_iss,
  output logic [1:0]       pipe_stall
);

  logic [NREG-1:0]  rdy;
  logic             dbl_busy;
  logic             dbl_fire;
  logic             wa_en, wb_en;
  logic [AW-1:0]    wa_idx, wb_idx;
  logic [CNT_W-1:0] wa_val, wb_val;

  vsb_ready_table #(.NREG(NREG)) u_table (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_val(wa_val),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
    .rdy(rdy)
  );

  vsb_dbl_unit #(.GAP(GAP)) u_dbl (
    .clk(clk), .rst(rst), .dbl_fire(dbl_fire), .busy(dbl_busy)
  );

  vsb_issue_ctl #(.NREG(NREG)) u_ctl (
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_wen(s0_wen),
    .s0_dst(s0_dst), .s0_sa(s0_sa), .s0_sb(s0_sb),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_wen(s1_wen),
    .s1_dst(s1_dst), .s1_sa(s1_sa), .s1_sb(s1_sb),
    .rdy(rdy), .dbl_busy(dbl_busy),
    .go0(s0_go), .go1(s1_go), .p_iss(pipe_iss), .p_stall(pipe_stall),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_val(wa_val),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
    .dbl_fire(dbl_fire)
  );

  // R1: pipe 1 issues only classes coded 6 and above
  p_pipe_route_r1: assert property (@(posedge clk) disable iff (rst)
    pipe_iss[1] |-> ((s0_go && s0_cls >= 4'd6) || (s1_go && s1_cls >= 4'd6)));

  // R3: an issuing older slot has both operands ready in the table
  p_src_ready_r3: assert property (@(posedge clk) disable iff (rst)
    s0_go |-> (rdy[s0_sa] && rdy[s0_sb]));

  // R5: a dual issue never carries a same-cycle dependency
  p_no_pair_dep_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_go && s0_wen && s0_cls <= 4'd7) |-> (s1_sa != s0_dst && s1_sb != s0_dst));

  // R6: the younger slot never overtakes the older one
  p_in_order_r6: assert property (@(posedge clk) disable iff (rst)
    s1_go |-> s0_go);

  // R9: a blocked older instruction always shows up as a stall
  p_stall_seen_r9: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && !s0_go) |-> (pipe_stall != 2'b00));

endmodule

// File: tb/vec_issue_sb_bench.sv
module vec_issue_sb_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       s0_vld, s0_wen, s1_vld, s1_wen;
  logic [3:0] s0_cls, s1_cls;
  logic [6:0] s0_dst, s0_sa, s0_sb, s1_dst, s1_sa, s1_sb;
  logic       s0_go, s1_go;
  logic [1:0] pipe_iss, pipe_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  vec_issue_sb u_vec_issue_sb (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_wen(s0_wen),
    .s0_dst(s0_dst), .s0_sa(s0_sa), .s0_sb(s0_sb),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_wen(s1_wen),
    .s1_dst(s1_dst), .s1_sa(s1_sa), .s1_sb(s1_sb),
    .s0_go(s0_go), .s1_go(s1_go), .pipe_iss(pipe_iss), .pipe_stall(pipe_stall)
  );

  function automatic int want_lat(input int c);
    int t[8] = '{2, 4, 7, 6, 7, 13, 4, 6};
    return t[c];
  endfunction

  function automatic int want_pipe(input int c);
    return (c < 6) ? 0 : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put0(input logic v, input int c, input logic w,
                      input int d, input int a, input int b);
    s0_vld = v; s0_cls = 4'(c); s0_wen = w;
    s0_dst = 7'(d); s0_sa = 7'(a); s0_sb = 7'(b);
  endtask

  task automatic put1(input logic v, input int c, input logic w,
                      input int d, input int a, input int b);
    s1_vld = v; s1_cls = 4'(c); s1_wen = w;
    s1_dst = 7'(d); s1_sa = 7'(a); s1_sb = 7'(b);
  endtask

  task automatic idle();
    put0(1'b0, 0, 1'b0, 0, 100, 100);
    put1(1'b0, 0, 1'b0, 0, 100, 100);
  endtask

  // move to just after the next rising edge
  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic drain(input int n);
    idle();
    for (int i = 0; i < n; i++) nxt();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle();
    repeat (3) nxt();
    rst = 1'b0;
    put0(1'b1, 0, 1'b1, 1, 2, 3);
    settle();
    chk("R8 go after reset", s0_go, 1);
    chk("R1 simple on pipe 0", pipe_iss, 2'b01);
    chk("R9 no stall", pipe_stall, 0);
    nxt();
    drain(2);
  endtask

  task automatic t_latency(input int c);
    int lat = want_lat(c);
    put0(1'b1, c, 1'b1, 10, 100, 101);
    put1(1'b0, 0, 1'b0, 0, 100, 100);
    settle();
    chk($sformatf("R1 class %0d issues", c), s0_go, 1);
    chk($sformatf("R1 class %0d pipe", c), pipe_iss, (want_pipe(c) == 0) ? 1 : 2);
    for (int k = 1; k <= lat; k++) begin
      nxt();
      put0(1'b1, 0, 1'b0, 0, 10, 10);
      settle();
      chk($sformatf("R2 R3 class %0d reader k=%0d", c, k), s0_go, (k == lat) ? 1 : 0);
    end
    nxt();
    drain(7);
  endtask

  task automatic t_dbl_gap();
    put0(1'b1, 5, 1'b1, 20, 100, 101);
    settle();
    chk("R4 first double", s0_go, 1);
    for (int k = 1; k <= 6; k++) begin
      nxt();
      put0(1'b1, 5, 1'b1, 21, 100, 101);
      settle();
      chk($sformatf("R4 slot0 double k=%0d", k), s0_go, (k == 6) ? 1 : 0);
    end
    for (int k = 1; k <= 6; k++) begin
      nxt();
      put0(1'b1, 7, 1'b0, 0, 100, 101);
      put1(1'b1, 5, 1'b1, 23, 102, 103);
      settle();
      chk($sformatf("R4 older load k=%0d", k), s0_go, 1);
      chk($sformatf("R4 slot1 double k=%0d", k), s1_go, (k == 6) ? 1 : 0);
    end
    nxt();
    drain(14);
  endtask

  task automatic t_dual();
    put0(1'b1, 0, 1'b1, 30, 100, 101);
    put1(1'b1, 7, 1'b1, 31, 102, 103);
    settle();
    chk("R5 pair go0", s0_go, 1);
    chk("R5 pair go1", s1_go, 1);
    chk("R1 both pipes", pipe_iss, 2'b11);
    nxt();
    put0(1'b1, 0, 1'b1, 32, 100, 101);
    put1(1'b1, 1, 1'b1, 33, 102, 103);
    settle();
    chk("R5 same pipe go1", s1_go, 0);
    chk("R9 same pipe stall", pipe_stall, 2'b01);
    nxt();
    put0(1'b1, 0, 1'b1, 34, 100, 101);
    put1(1'b1, 7, 1'b1, 36, 34, 103);
    settle();
    chk("R5 dependent go0", s0_go, 1);
    chk("R5 dependent go1", s1_go, 0);
    chk("R9 dependent stall", pipe_stall, 2'b10);
    nxt();
    put0(1'b1, 0, 1'b1, 35, 100, 101);
    put1(1'b0, 0, 1'b0, 0, 100, 100);
    settle();
    chk("R3 writer of 35", s0_go, 1);
    nxt();
    put0(1'b1, 0, 1'b0, 0, 35, 100);
    put1(1'b1, 7, 1'b0, 0, 102, 103);
    settle();
    chk("R3 blocked older", s0_go, 0);
    chk("R6 younger held", s1_go, 0);
    chk("R9 both stall", pipe_stall, 2'b11);
    nxt();
    drain(8);
  endtask

  task automatic t_keep();
    put0(1'b1, 5, 1'b1, 40, 100, 101);
    settle();
    chk("R7 double writer", s0_go, 1);
    nxt();
    put0(1'b1, 0, 1'b1, 40, 100, 101);
    settle();
    chk("R7 short writer", s0_go, 1);
    for (int k = 2; k <= 13; k++) begin
      nxt();
      put0(1'b1, 0, 1'b0, 0, 40, 100);
      settle();
      chk($sformatf("R7 reader k=%0d", k), s0_go, (k == 13) ? 1 : 0);
    end
    nxt();
    drain(8);
  endtask

  task automatic t_branch();
    put0(1'b1, 8, 1'b1, 41, 100, 101);
    settle();
    chk("R1 branch on pipe 1", pipe_iss, 2'b10);
    nxt();
    put0(1'b1, 0, 1'b0, 0, 41, 41);
    settle();
    chk("R10 branch dst free", s0_go, 1);
    nxt();
    put0(1'b1, 7, 1'b0, 42, 100, 101);
    settle();
    chk("R10 no-write issue", s0_go, 1);
    nxt();
    put0(1'b1, 0, 1'b0, 0, 42, 42);
    settle();
    chk("R10 no-write dst free", s0_go, 1);
    nxt();
    drain(2);
  endtask

  task automatic t_rst_mid();
    put0(1'b1, 5, 1'b1, 50, 100, 101);
    settle();
    chk("R8 double before reset", s0_go, 1);
    nxt();
    idle();
    rst = 1'b1;
    nxt();
    rst = 1'b0;
    put0(1'b1, 5, 1'b1, 51, 50, 50);
    settle();
    chk("R8 cleared after reset", s0_go, 1);
    nxt();
    drain(14);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    #2;
    t_reset();
    for (int c = 0; c < 8; c++) t_latency(c);
    t_dbl_gap();
    t_dual();
    t_keep();
    t_branch();
    t_rst_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule